// File: doc/BRIEF.md
# Keyboard Controller Command Engine

This block is the host-side register interface of a PC-style keyboard and mouse controller. The host sees two byte-wide ports, selected by one address bit: a data port and a command port. Writes to the command port are decoded as single-byte controller commands. Some commands act at once. They can change the mode byte, change the output port, produce a reply byte or request a system reset. Other commands arm a pending write target, and the next data-port write completes that target.

Replies leave through a one-cycle reply strobe, tagged as keyboard-sourced or mouse-sourced, and go to a separate output-buffer arbiter. Data that is meant for the attached devices leaves through per-device forward strobes. The block holds the output-port byte and drives the A20 gate from bit 1 of that byte. It also raises a registered one-cycle system reset request.

Every output is registered. The effect of a write at a clock edge is therefore visible in the cycle that follows that edge.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset, statusByte is 0x18, outPort is 0xCF, a20Gate is 1, and the mode byte is 0x03 (a later 0x20 command replies 0x03). No strobe is active.
- R2: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending target. The next data-port write consumes the target and returns it to idle, so the data write after that goes to the keyboard. A command that does not arm a target leaves an armed target in place.
- R3: A data-port write with no target armed pulses kbdTxValid with devTxData equal to the written byte, and clears mode bit 4.
- R4: A data-port write with target 0xD4 pulses mouseTxValid with devTxData equal to the byte, and clears mode bit 5.
- R5: Command 0xAD sets mode bit 4 and 0xAE clears it. Command 0xA7 sets mode bit 5 and 0xA8 clears it.
- R6: Command 0x20 replies with the mode byte. A data write with target 0x60 loads the whole mode byte.
- R7: Command 0xAA sets statusByte bit 2 and replies 0x55. Commands 0xA9 and 0xAB reply 0x00, 0xC0 replies 0x80, and 0xD0 replies with the current outPort. All of these replies have replyAux 0.
- R8: A data write with target 0xD2 replies the byte with replyAux 0. With target 0xD3 it replies the byte with replyAux 1.
- R9: Any command whose upper nibble is 0xF raises sysResetReq for exactly one cycle when its bit 0 is 0. When bit 0 is 1 the command has no effect and raises no error.
- R10: Command 0xDF sets outPort bit 1 and raises a20Gate. Command 0xDD clears outPort bit 1 and lowers a20Gate.
- R11: A data write with target 0xD1 loads outPort with the byte, and a20Gate follows bit 1 of the byte. When bit 0 of the byte is 0, sysResetReq pulses for one cycle.
- R12: A command code that is not listed above raises cmdError for one cycle and changes no state.
- R13: statusByte bit 3 is set by every command-port write and cleared by every data-port write. Bit 4 is always 1, and all other bits except bit 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostSel | input | 1 | 1 selects the command port, 0 selects the data port |
| hostData | input | 8 | Host write byte |
| statusByte | output | 8 | Status byte, less the buffer-full flags |
| replyValid | output | 1 | One-cycle reply strobe to the output-buffer arbiter |
| replyAux | output | 1 | Reply is tagged as mouse-sourced |
| replyData | output | 8 | Reply byte |
| kbdTxValid | output | 1 | Byte forwarded to the keyboard |
| mouseTxValid | output | 1 | Byte forwarded to the mouse |
| devTxData | output | 8 | Forwarded byte |
| outPort | output | 8 | Output-port byte |
| a20Gate | output | 1 | A20 gate level |
| sysResetReq | output | 1 | One-cycle system reset request |
| cmdError | output | 1 | One-cycle unsupported-command flag |

## Verification
The assertions check the following on every cycle:
- Each reset request, reply, forward strobe and error strobe traces back to a host write in the cycle before.
- At most one of the reply, forward and error strobes is active at a time.
- Forwarded bytes equal the byte that was written.
- An error never coincides with an output-port change.
- Command-port writes and 0xDF leave their marks in statusByte and outPort.

The following rest on the bench scenarios and the cycle-accurate model:
- How an armed target survives unrelated commands and is then consumed.
- How the mode bits change, which is visible only through a later 0x20 reply.
- The folding of the 0xF0 to 0xFF commands into reset or no-op.

// File: rtl/kbc_cmd_pkg.sv
package kbc_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  typedef logic [BYTE_W-1:0] byte_t;

  // mode byte bit positions
  localparam int KBD_OFF_BIT = 4;
  localparam int AUX_OFF_BIT = 5;
  // output port bit positions
  localparam int RUN_BIT = 0;
  localparam int A20_BIT = 1;
  // status bit positions
  localparam int STAT_SELF_BIT = 2;
  localparam int STAT_CMD_BIT  = 3;
  localparam int STAT_OPEN_BIT = 4;

  // command codes
  localparam byte_t OP_MODE_RD   = 8'h20;
  localparam byte_t OP_MODE_WR   = 8'h60;
  localparam byte_t OP_AUX_OFF   = 8'hA7;
  localparam byte_t OP_AUX_ON    = 8'hA8;
  localparam byte_t OP_AUX_TEST  = 8'hA9;
  localparam byte_t OP_SELF_TEST = 8'hAA;
  localparam byte_t OP_KBD_TEST  = 8'hAB;
  localparam byte_t OP_KBD_OFF   = 8'hAD;
  localparam byte_t OP_KBD_ON    = 8'hAE;
  localparam byte_t OP_IN_RD     = 8'hC0;
  localparam byte_t OP_PORT_RD   = 8'hD0;
  localparam byte_t OP_PORT_WR   = 8'hD1;
  localparam byte_t OP_ECHO_KBD  = 8'hD2;
  localparam byte_t OP_ECHO_AUX  = 8'hD3;
  localparam byte_t OP_TO_AUX    = 8'hD4;
  localparam byte_t OP_GATE_OFF  = 8'hDD;
  localparam byte_t OP_GATE_ON   = 8'hDF;
  localparam byte_t OP_CPU_RST   = 8'hFE;
  localparam byte_t OP_NOP       = 8'hFF;
  localparam byte_t TGT_NONE     = 8'h00;

  localparam logic [NIB_W-1:0] PULSE_NIB = 4'hF;

  typedef enum logic [1:0] {SRC_MODE, SRC_PORT, SRC_CONST, SRC_HOST} reply_src_e;

  typedef struct packed {
    logic       cmdMark;
    logic       dataMark;
    logic       modeLoad;
    byte_t      modeSet;
    byte_t      modeClr;
    logic       portLoad;
    logic       a20On;
    logic       a20Off;
    logic       selfTest;
    logic       armTarget;
    logic       dropTarget;
    logic       replyEn;
    logic       replyAux;
    reply_src_e replySrc;
    byte_t      replyConst;
    logic       kbdFwd;
    logic       mouseFwd;
    logic       resetPulse;
    logic       errPulse;
  } strobe_t;
endpackage

// File: rtl/kbc_cmd_ctrl.sv
module kbc_cmd_ctrl
  import kbc_cmd_pkg::*;
(
  input  logic    hostWr,
  input  logic    hostSel,
  input  byte_t   hostData,
  input  byte_t   armedOp,
  output strobe_t st
);
  byte_t op;

  // the 0xF0..0xFF group collapses onto two codes
  always_comb begin
    op = hostData;
    if (hostData[BYTE_W-1 -: NIB_W] == PULSE_NIB)
      op = hostData[RUN_BIT] ? OP_NOP : OP_CPU_RST;
  end

  always_comb begin
    st = '0;
    if (hostWr && hostSel) begin
      st.cmdMark = 1'b1;
      unique case (op)
        OP_MODE_RD: begin
          st.replyEn  = 1'b1;
          st.replySrc = SRC_MODE;
        end
        OP_MODE_WR, OP_PORT_WR, OP_ECHO_KBD, OP_ECHO_AUX, OP_TO_AUX:
          st.armTarget = 1'b1;
        OP_AUX_OFF: st.modeSet[AUX_OFF_BIT] = 1'b1;
        OP_AUX_ON:  st.modeClr[AUX_OFF_BIT] = 1'b1;
        OP_KBD_OFF: st.modeSet[KBD_OFF_BIT] = 1'b1;
        OP_KBD_ON:  st.modeClr[KBD_OFF_BIT] = 1'b1;
        OP_AUX_TEST, OP_KBD_TEST: begin
          st.replyEn    = 1'b1;
          st.replySrc   = SRC_CONST;
          st.replyConst = 8'h00;
        end
        OP_SELF_TEST: begin
          st.selfTest   = 1'b1;
          st.replyEn    = 1'b1;
          st.replySrc   = SRC_CONST;
          st.replyConst = 8'h55;
        end
        OP_IN_RD: begin
          st.replyEn    = 1'b1;
          st.replySrc   = SRC_CONST;
          st.replyConst = 8'h80;
        end
        OP_PORT_RD: begin
          st.replyEn  = 1'b1;
          st.replySrc = SRC_PORT;
        end
        OP_GATE_OFF: st.a20Off     = 1'b1;
        OP_GATE_ON:  st.a20On      = 1'b1;
        OP_CPU_RST:  st.resetPulse = 1'b1;
        OP_NOP:      ;
        default:     st.errPulse   = 1'b1;
      endcase
    end else if (hostWr) begin
      st.dataMark   = 1'b1;
      st.dropTarget = 1'b1;
      case (armedOp)
        TGT_NONE: begin
          st.kbdFwd               = 1'b1;
          st.modeClr[KBD_OFF_BIT] = 1'b1;
        end
        OP_MODE_WR: st.modeLoad = 1'b1;
        OP_PORT_WR: begin
          st.portLoad   = 1'b1;
          st.resetPulse = ~hostData[RUN_BIT];
        end
        OP_ECHO_KBD: begin
          st.replyEn  = 1'b1;
          st.replySrc = SRC_HOST;
        end
        OP_ECHO_AUX: begin
          st.replyEn  = 1'b1;
          st.replyAux = 1'b1;
          st.replySrc = SRC_HOST;
        end
        OP_TO_AUX: begin
          st.mouseFwd             = 1'b1;
          st.modeClr[AUX_OFF_BIT] = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbc_cmd_dp.sv
module kbc_cmd_dp
  import kbc_cmd_pkg::*;
#(
  parameter byte_t MODE_INIT = 8'h03,
  parameter byte_t PORT_INIT = 8'hCF
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t st,
  input  byte_t   hostData,
  output byte_t   armedOp,
  output byte_t   statusByte,
  output logic    replyValid,
  output logic    replyAux,
  output byte_t   replyData,
  output logic    kbdTxValid,
  output logic    mouseTxValid,
  output byte_t   devTxData,
  output byte_t   outPort,
  output logic    a20Gate,
  output logic    sysResetReq,
  output logic    cmdError
);
  byte_t modeQ, portQ, targetQ, replyNext;
  logic  selfQ, cmdFlagQ;

  always_comb begin
    unique case (st.replySrc)
      SRC_MODE:  replyNext = modeQ;
      SRC_PORT:  replyNext = portQ;
      SRC_CONST: replyNext = st.replyConst;
      default:   replyNext = hostData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ        <= MODE_INIT;
      portQ        <= PORT_INIT;
      targetQ      <= TGT_NONE;
      selfQ        <= 1'b0;
      cmdFlagQ     <= 1'b1;
      replyValid   <= 1'b0;
      replyAux     <= 1'b0;
      replyData    <= '0;
      kbdTxValid   <= 1'b0;
      mouseTxValid <= 1'b0;
      devTxData    <= '0;
      sysResetReq  <= 1'b0;
      cmdError     <= 1'b0;
    end else begin
      if (st.modeLoad) modeQ <= hostData;
      else             modeQ <= (modeQ | st.modeSet) & ~st.modeClr;

      if (st.portLoad)    portQ          <= hostData;
      else if (st.a20On)  portQ[A20_BIT] <= 1'b1;
      else if (st.a20Off) portQ[A20_BIT] <= 1'b0;

      if (st.armTarget)       targetQ <= hostData;
      else if (st.dropTarget) targetQ <= TGT_NONE;

      if (st.selfTest) selfQ <= 1'b1;
      if (st.cmdMark)       cmdFlagQ <= 1'b1;
      else if (st.dataMark) cmdFlagQ <= 1'b0;

      replyValid <= st.replyEn;
      if (st.replyEn) begin
        replyData <= replyNext;
        replyAux  <= st.replyAux;
      end
      kbdTxValid   <= st.kbdFwd;
      mouseTxValid <= st.mouseFwd;
      if (st.kbdFwd || st.mouseFwd) devTxData <= hostData;
      sysResetReq <= st.resetPulse;
      cmdError    <= st.errPulse;
    end
  end

  always_comb begin
    statusByte                = '0;
    statusByte[STAT_SELF_BIT] = selfQ;
    statusByte[STAT_CMD_BIT]  = cmdFlagQ;
    statusByte[STAT_OPEN_BIT] = 1'b1;
  end

  assign armedOp = targetQ;
  assign outPort = portQ;
  assign a20Gate = portQ[A20_BIT];
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_cmd_pkg::*;
#(
  parameter byte_t MODE_INIT = 8'h03,
  parameter byte_t PORT_INIT = 8'hCF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostSel,
  input  logic [BYTE_W-1:0] hostData,
  output logic [BYTE_W-1:0] statusByte,
  output logic              replyValid,
  output logic              replyAux,
  output logic [BYTE_W-1:0] replyData,
  output logic              kbdTxValid,
  output logic              mouseTxValid,
  output logic [BYTE_W-1:0] devTxData,
  output logic [BYTE_W-1:0] outPort,
  output logic              a20Gate,
  output logic              sysResetReq,
  output logic              cmdError
);
  strobe_t st;
  byte_t   armedOp;

  kbc_cmd_ctrl u_ctrl (
    .hostWr  (hostWr),
    .hostSel (hostSel),
    .hostData(hostData),
    .armedOp (armedOp),
    .st      (st)
  );

  kbc_cmd_dp #(.MODE_INIT(MODE_INIT), .PORT_INIT(PORT_INIT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .hostData    (hostData),
    .armedOp     (armedOp),
    .statusByte  (statusByte),
    .replyValid  (replyValid),
    .replyAux    (replyAux),
    .replyData   (replyData),
    .kbdTxValid  (kbdTxValid),
    .mouseTxValid(mouseTxValid),
    .devTxData   (devTxData),
    .outPort     (outPort),
    .a20Gate     (a20Gate),
    .sysResetReq (sysResetReq),
    .cmdError    (cmdError)
  );
endmodule

// File: rtl/kbc_cmd_checker.sv
module kbc_cmd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hostWr,
  input logic       hostSel,
  input logic [7:0] hostData,
  input logic [7:0] statusByte,
  input logic       replyValid,
  input logic       kbdTxValid,
  input logic       mouseTxValid,
  input logic [7:0] devTxData,
  input logic [7:0] outPort,
  input logic       sysResetReq,
  input logic       cmdError
);
  AST_RESET_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(hostWr)); // R9
  AST_REPLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |-> $past(hostWr)); // R7
  AST_ERROR_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $past(hostWr && hostSel)); // R12
  AST_ERROR_KEEPS_PORT: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $stable(outPort)); // R12
  AST_KBD_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    kbdTxValid |-> ($past(hostWr && !hostSel) && devTxData == $past(hostData))); // R3
  AST_MOUSE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    mouseTxValid |-> ($past(hostWr && !hostSel) && devTxData == $past(hostData))); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({replyValid, kbdTxValid, mouseTxValid, cmdError})); // R2
  AST_GATE_ON: assert property (@(posedge clk) disable iff (!rstN)
    $past(hostWr && hostSel && hostData == 8'hDF) |-> outPort[1]); // R10
  AST_CMD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $past(hostWr && hostSel) |-> statusByte[3]); // R13
endmodule

bind kbc_cmd_engine kbc_cmd_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostWr      (hostWr),
  .hostSel     (hostSel),
  .hostData    (hostData),
  .statusByte  (statusByte),
  .replyValid  (replyValid),
  .kbdTxValid  (kbdTxValid),
  .mouseTxValid(mouseTxValid),
  .devTxData   (devTxData),
  .outPort     (outPort),
  .sysResetReq (sysResetReq),
  .cmdError    (cmdError)
);

// File: tb/test_kbc_cmd_engine.sv
`timescale 1ns/1ps
module test_kbc_cmd_engine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostSel = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic [7:0] statusByte, replyData, devTxData, outPort;
  logic       replyValid, replyAux, kbdTxValid, mouseTxValid, a20Gate, sysResetReq, cmdError;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  kbc_cmd_engine i_kbc_cmd_engine (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostSel(hostSel), .hostData(hostData),
    .statusByte(statusByte), .replyValid(replyValid), .replyAux(replyAux),
    .replyData(replyData), .kbdTxValid(kbdTxValid), .mouseTxValid(mouseTxValid),
    .devTxData(devTxData), .outPort(outPort), .a20Gate(a20Gate),
    .sysResetReq(sysResetReq), .cmdError(cmdError)
  );

  // behavioural reference model
  logic [7:0] mMode, mOut, mTarget, eRd, eDd;
  logic       mSelf, mCmd, eRv, eRa, eKv, eMv, eRst, eErr;

  always @(posedge clk) begin
    eRv = 0; eKv = 0; eMv = 0; eRst = 0; eErr = 0;
    if (!rstN) begin
      mMode = 8'h03; mOut = 8'hCF; mTarget = 8'h00; mSelf = 0; mCmd = 1;
      eRa = 0; eRd = 0; eDd = 0;
    end else if (hostWr && hostSel) begin
      mCmd = 1;
      if (hostData >= 8'hF0) begin
        if (!hostData[0]) eRst = 1;
      end else begin
        case (hostData)
          8'h20: begin eRv = 1; eRa = 0; eRd = mMode; end
          8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: mTarget = hostData;
          8'hA7: mMode = mMode | 8'h20;
          8'hA8: mMode = mMode & 8'hDF;
          8'hAD: mMode = mMode | 8'h10;
          8'hAE: mMode = mMode & 8'hEF;
          8'hA9, 8'hAB: begin eRv = 1; eRa = 0; eRd = 8'h00; end
          8'hAA: begin mSelf = 1; eRv = 1; eRa = 0; eRd = 8'h55; end
          8'hC0: begin eRv = 1; eRa = 0; eRd = 8'h80; end
          8'hD0: begin eRv = 1; eRa = 0; eRd = mOut; end
          8'hDD: mOut = mOut & 8'hFD;
          8'hDF: mOut = mOut | 8'h02;
          default: eErr = 1;
        endcase
      end
    end else if (hostWr) begin
      mCmd = 0;
      case (mTarget)
        8'h00: begin eKv = 1; eDd = hostData; mMode = mMode & 8'hEF; end
        8'h60: mMode = hostData;
        8'hD1: begin mOut = hostData; eRst = !hostData[0]; end
        8'hD2: begin eRv = 1; eRa = 0; eRd = hostData; end
        8'hD3: begin eRv = 1; eRa = 1; eRd = hostData; end
        8'hD4: begin eMv = 1; eDd = hostData; mMode = mMode & 8'hDF; end
        default: ;
      endcase
      mTarget = 8'h00;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(statusByte, {3'b000, 1'b1, mCmd, mSelf, 2'b00}, "R13 statusByte");
      check(outPort, mOut, "R11 outPort");
      check({7'd0, a20Gate}, {7'd0, mOut[1]}, "R10 a20Gate");
      check({7'd0, replyValid}, {7'd0, eRv}, "R7 replyValid");
      if (eRv) begin
        check(replyData, eRd, "R8 replyData");
        check({7'd0, replyAux}, {7'd0, eRa}, "R8 replyAux");
      end
      check({7'd0, kbdTxValid}, {7'd0, eKv}, "R3 kbdTxValid");
      check({7'd0, mouseTxValid}, {7'd0, eMv}, "R4 mouseTxValid");
      if (eKv || eMv) check(devTxData, eDd, "R3 devTxData");
      check({7'd0, sysResetReq}, {7'd0, eRst}, "R9 sysResetReq");
      check({7'd0, cmdError}, {7'd0, eErr}, "R12 cmdError");
    end
  end

  // one write, returning at the negedge after the capturing edge
  task automatic put(input logic sel, input logic [7:0] d);
    hostWr = 1; hostSel = sel; hostData = d;
    @(negedge clk);
    hostWr = 0;
  endtask
  task automatic cmd(input logic [7:0] d); put(1'b1, d); endtask
  task automatic dat(input logic [7:0] d); put(1'b0, d); endtask
  task automatic idle(); @(negedge clk); endtask

  task automatic finishRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    idle();
    // R1 reset state
    check(statusByte, 8'h18, "R1 status");
    check(outPort, 8'hCF, "R1 outPort");
    check({7'd0, a20Gate}, 8'h01, "R1 a20Gate");
    cmd(8'h20); check(replyData, 8'h03, "R1 mode");
    // R7 fixed replies
    cmd(8'hAA); check(replyData, 8'h55, "R7 self test"); check(statusByte, 8'h1C, "R7 status bit2");
    cmd(8'hA9); check(replyData, 8'h00, "R7 aux test");
    cmd(8'hC0); check(replyData, 8'h80, "R7 input read");
    cmd(8'hD0); check(replyData, 8'hCF, "R7 port read");
    // R5 mode bits
    cmd(8'hAD); cmd(8'h20); check(replyData, 8'h13, "R5 kbd off");
    cmd(8'hA7); cmd(8'h20); check(replyData, 8'h33, "R5 aux off");
    cmd(8'hAE); cmd(8'hA8); cmd(8'h20); check(replyData, 8'h03, "R5 both on");
    // R3 keyboard forward
    cmd(8'hAD); dat(8'h5A);
    check({7'd0, kbdTxValid}, 8'h01, "R3 kbd strobe"); check(devTxData, 8'h5A, "R3 kbd byte");
    check(statusByte, 8'h14, "R13 data clears bit3");
    cmd(8'h20); check(replyData, 8'h03, "R3 bit4 cleared");
    // R4 mouse forward
    cmd(8'hA7); cmd(8'hD4); dat(8'h77);
    check({7'd0, mouseTxValid}, 8'h01, "R4 mouse strobe"); check(devTxData, 8'h77, "R4 mouse byte");
    cmd(8'h20); check(replyData, 8'h03, "R4 bit5 cleared");
    // R6 mode load
    cmd(8'h60); dat(8'hF5); cmd(8'h20); check(replyData, 8'hF5, "R6 mode load");
    cmd(8'h60); dat(8'h03);
    // R8 echoes
    cmd(8'hD2); dat(8'h11); check(replyData, 8'h11, "R8 kbd echo"); check({7'd0, replyAux}, 8'h00, "R8 kbd tag");
    cmd(8'hD3); dat(8'h22); check(replyData, 8'h22, "R8 aux echo"); check({7'd0, replyAux}, 8'h01, "R8 aux tag");
    // R2 target survives unrelated command, then is consumed
    cmd(8'hD2); cmd(8'hAD); dat(8'h33);
    check({7'd0, replyValid}, 8'h01, "R2 armed kept"); check(replyData, 8'h33, "R2 armed byte");
    dat(8'h44); check({7'd0, kbdTxValid}, 8'h01, "R2 target cleared");
    // R10 gate
    cmd(8'hDD); check(outPort, 8'hCD, "R10 gate off"); check({7'd0, a20Gate}, 8'h00, "R10 a20 low");
    cmd(8'hDF); check(outPort, 8'hCF, "R10 gate on"); check({7'd0, a20Gate}, 8'h01, "R10 a20 high");
    // R11 port write
    cmd(8'hD1); dat(8'h0C);
    check(outPort, 8'h0C, "R11 port"); check({7'd0, sysResetReq}, 8'h01, "R11 reset pulse");
    idle(); check({7'd0, sysResetReq}, 8'h00, "R11 pulse width");
    cmd(8'hD1); dat(8'hCF); check({7'd0, sysResetReq}, 8'h00, "R11 no reset");
    check({7'd0, a20Gate}, 8'h01, "R11 a20 follows");
    // R9 pulse group
    cmd(8'hFE); check({7'd0, sysResetReq}, 8'h01, "R9 FE");
    idle(); check({7'd0, sysResetReq}, 8'h00, "R9 one cycle");
    cmd(8'hF0); check({7'd0, sysResetReq}, 8'h01, "R9 F0");
    cmd(8'hF1); check({7'd0, sysResetReq}, 8'h00, "R9 F1 nop"); check({7'd0, cmdError}, 8'h00, "R9 F1 no error");
    cmd(8'hFF); check({7'd0, cmdError}, 8'h00, "R9 FF no error");
    // R12 unsupported
    cmd(8'h12); check({7'd0, cmdError}, 8'h01, "R12 error");
    idle(); check({7'd0, cmdError}, 8'h00, "R12 one cycle");
    cmd(8'hE5); check(outPort, 8'hCF, "R12 no change");
    cmd(8'h20); check(replyData, 8'h03, "R12 mode kept");
    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      int pick;
      logic [7:0] c;
      pick = $urandom_range(0, 23);
      case (pick)
        0: c = 8'h20;  1: c = 8'h60;  2: c = 8'hA7;  3: c = 8'hA8;
        4: c = 8'hA9;  5: c = 8'hAA;  6: c = 8'hAB;  7: c = 8'hAD;
        8: c = 8'hAE;  9: c = 8'hC0; 10: c = 8'hD0; 11: c = 8'hD1;
        12: c = 8'hD2; 13: c = 8'hD3; 14: c = 8'hD4; 15: c = 8'hDD;
        16: c = 8'hDF; 17: c = 8'hF0 | 8'($urandom_range(0, 15));
        18: c = 8'($urandom_range(0, 255));
        default: c = 8'h00;
      endcase
      if (pick >= 19) dat(8'($urandom_range(0, 255)));
      else cmd(c);
      if ((i % 5) == 0) idle();
    end
    idle();
    finishRun();
  end
endmodule